// File: doc/BRIEF.md
# Rotate-Mask Jump Table Dispatcher

This block works out the target of a register-indexed relative jump. A jump table sits right after the jump instruction, and a bit field inside a received data word picks the entry. The block takes a copy of an 8-bit operand and rotates it right by a programmable count. It then clears a programmable number of upper bits and also clears bit 0. The remaining byte is treated as a signed displacement and added to the program counter. That program counter already addresses the instruction after the jump.

Because bit 0 is always cleared, every displacement is even. A table can therefore hold one-word or two-word entries. A field at bits 4:2 with a rotate count of 1 and a mask count of 4 lands at bits 3:1, so each step of the field moves the target by two words. The operand itself is only read and is never written back. The new program counter is registered and appears one cycle after the start strobe, together with a single-cycle done pulse.

Top module: `rmjump_dispatch`

## Requirements
- R1: While reset is asserted, and after it is released with no start, `pc_o` reads 0 and `done_o` reads 0.
- R2: The operand is rotated right by `rot_i` (0 to 7). A bit leaving position 0 re-enters at position 7, and `rot_i`=0 leaves the bit order unchanged.
- R3: After the rotation, the upper `mask_i` bits (0 to 7) of the byte are cleared before use. With `mask_i`=0 no upper bit is cleared.
- R4: Bit 0 of the displacement is always cleared, so `pc_o` minus the base program counter is always even.
- R5: The masked byte is sign-extended from bit 7 and added to `pc_i`, and the sum wraps modulo 2^16. The reachable span is -128 to +126.
- R6: When `start_i` is high at a rising edge, the new program counter appears on `pc_o` after that edge, and `done_o` is high for that cycle. `done_o` is low in any cycle that does not follow a start.
- R7: Without a start, `pc_o` keeps its last value.
- R8: Starts on consecutive cycles each produce their own result, one cycle after their own operands.
- R9: With `rot_i`=1 and `mask_i`=4, the field at operand bits 4:2 becomes a displacement of twice the field value. A field of 001 gives `pc_i`+2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Compute a jump target from the operands this cycle |
| src_i | input | 8 | Operand holding the selector field |
| rot_i | input | 3 | Right-rotate count |
| mask_i | input | 3 | Number of upper bits cleared after rotation |
| pc_i | input | 16 | Program counter of the instruction following the jump |
| pc_o | output | 16 | Computed jump target |
| done_o | output | 1 | One-cycle pulse marking a fresh `pc_o` |

## Verification
Two functions can fall in the same cycle: presenting one result on `pc_o`/`done_o` and capturing the operands of the next jump. The bench provokes this with long runs of back-to-back start strobes, using random operands. It judges each cycle's `pc_o` against a value computed from that cycle's own earlier operands only. A second overlap sits inside the datapath: bits that the rotation wraps from the bottom into the top are then the bits the mask clears. Directed cases with large rotate and mask counts show that the wrapped bits are cleared after they move and never before.

// File: rtl/rmj_pkg.sv
package rmj_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned PC_W   = 16;
  localparam int unsigned CNT_W  = $clog2(DATA_W);

  typedef logic [DATA_W-1:0] byte_t;
  typedef logic [PC_W-1:0]   pc_t;
  typedef logic [CNT_W-1:0]  cnt_t;
endpackage

// File: rtl/rmj_rotator.sv
module rmj_rotator #(
  parameter int unsigned W  = 8,
  parameter int unsigned CW = $clog2(W)
) (
  input  logic [W-1:0]  data_i,
  input  logic [CW-1:0] amt_i,
  output logic [W-1:0]  data_o
);
  logic [W-1:0] stage [0:CW];

  assign stage[0] = data_i;

  // log-depth barrel: stage k rotates right by 2**k when amt_i[k] is set
  for (genvar k = 0; k < CW; k++) begin : g_stage
    localparam int unsigned SH = 2 ** k;
    logic [W-1:0] rotated;
    assign rotated      = {stage[k][SH-1:0], stage[k][W-1:SH]};
    assign stage[k+1]   = amt_i[k] ? rotated : stage[k];
  end

  assign data_o = stage[CW];
endmodule

// File: rtl/rmj_masker.sv
module rmj_masker #(
  parameter int unsigned W  = 8,
  parameter int unsigned CW = $clog2(W)
) (
  input  logic [W-1:0]  data_i,
  input  logic [CW-1:0] clr_i,
  output logic [W-1:0]  data_o
);
  logic [W-1:0] keep;

  // bit 0 is always dropped; bit i survives while i < W - clr_i
  for (genvar i = 0; i < W; i++) begin : g_keep
    if (i == 0) begin : g_lsb
      assign keep[i] = 1'b0;
    end else begin : g_upper
      localparam int unsigned LIM = W - i;
      assign keep[i] = ({1'b0, clr_i} < (CW+1)'(LIM));
    end
  end

  assign data_o = data_i & keep;
endmodule

// File: rtl/rmj_pc_adder.sv
module rmj_pc_adder #(
  parameter int unsigned W    = 8,
  parameter int unsigned PW   = 16
) (
  input  logic [W-1:0]  disp_i,
  input  logic [PW-1:0] base_i,
  output logic [PW-1:0] sum_o
);
  localparam int unsigned EXT_W = PW - W;

  logic [PW-1:0] disp_ext;

  assign disp_ext = {{EXT_W{disp_i[W-1]}}, disp_i};
  assign sum_o    = base_i + disp_ext;
endmodule

// File: rtl/rmjump_dispatch.sv
module rmjump_dispatch
  import rmj_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [7:0]  src_i,
  input  logic [2:0]  rot_i,
  input  logic [2:0]  mask_i,
  input  logic [15:0] pc_i,
  output logic [15:0] pc_o,
  output logic        done_o
);
  byte_t rot_val;
  byte_t disp;
  pc_t   target;
  pc_t   pc_d, pc_q;
  logic  done_d, done_q;
  logic  pc_en;

  rmj_rotator #(.W(DATA_W), .CW(CNT_W)) u_rot (
    .data_i (src_i),
    .amt_i  (rot_i),
    .data_o (rot_val)
  );

  rmj_masker #(.W(DATA_W), .CW(CNT_W)) u_msk (
    .data_i (rot_val),
    .clr_i  (mask_i),
    .data_o (disp)
  );

  rmj_pc_adder #(.W(DATA_W), .PW(PC_W)) u_add (
    .disp_i (disp),
    .base_i (pc_i),
    .sum_o  (target)
  );

  // next state
  always_comb begin
    pc_en  = start_i;
    pc_d   = pc_en ? target : pc_q;
    done_d = start_i;
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= '0;
      done_q <= 1'b0;
    end else begin
      pc_q   <= pc_d;
      done_q <= done_d;
    end
  end

  assign pc_o   = pc_q;
  assign done_o = done_q;
endmodule

// File: rtl/rmj_checker.sv
module rmj_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        start_i,
  input logic [2:0]  mask_i,
  input logic [15:0] pc_i,
  input logic [15:0] pc_o,
  input logic        done_o
);
  logic [15:0] base_q;
  logic        seen_q;
  logic [15:0] delta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      seen_q <= 1'b0;
    end else if (start_i) begin
      base_q <= pc_i;
      seen_q <= 1'b1;
    end
  end

  assign delta = pc_o - base_q;

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_q |-> (pc_o == 16'h0000 && !done_o));

  // R6
  done_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> done_o);

  // R6
  no_spurious_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> !done_o);

  // R7
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> $stable(pc_o));

  // R4
  even_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (delta[0] == 1'b0));

  // R3
  masked_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && mask_i != 3'd0) |=> (delta[15:7] == 9'd0));

  // R5
  span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (delta[15:7] == 9'd0 || delta[15:7] == 9'h1FF));
endmodule

bind rmjump_dispatch rmj_checker chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .start_i (start_i),
  .mask_i  (mask_i),
  .pc_i    (pc_i),
  .pc_o    (pc_o),
  .done_o  (done_o)
);

// File: tb/rmjump_dispatch_tb_top.sv
module rmjump_dispatch_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 100000;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [7:0]  src_i;
  logic [2:0]  rot_i;
  logic [2:0]  mask_i;
  logic [15:0] pc_i;
  logic [15:0] pc_o;
  logic        done_o;

  int checks = 0;
  int errors = 0;
  logic [15:0] hold_pc = 16'h0000;

  rmjump_dispatch dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .src_i(src_i),
    .rot_i(rot_i), .mask_i(mask_i), .pc_i(pc_i), .pc_o(pc_o), .done_o(done_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] exp_target(input logic [7:0] s, input logic [2:0] r,
                                             input logic [2:0] m, input logic [15:0] pc);
    logic [7:0] v = s;
    for (int k = 0; k < int'(r); k++) v = {v[0], v[7:1]};
    for (int i = 0; i < 8; i++) if (i == 0 || i >= 8 - int'(m)) v[i] = 1'b0;
    return pc + {{8{v[7]}}, v};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at a falling edge, check at the next falling edge
  task automatic step(input string req, input logic st, input logic [7:0] s,
                      input logic [2:0] r, input logic [2:0] m, input logic [15:0] pc);
    logic [15:0] e;
    start_i = st; src_i = s; rot_i = r; mask_i = m; pc_i = pc;
    e = st ? exp_target(s, r, m, pc) : hold_pc;
    @(negedge clk);
    check(req, pc_o, e);
    check({req, " done"}, {15'd0, done_o}, {15'd0, st});
    hold_pc = e;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; start_i = 1'b0; src_i = '0; rot_i = '0; mask_i = '0; pc_i = '0;
    repeat (3) @(negedge clk);
    check("R1 reset pc", pc_o, 16'h0000);
    check("R1 reset done", {15'd0, done_o}, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle pc", pc_o, 16'h0000);
    check("R1 idle done", {15'd0, done_o}, 16'h0000);

    // R9 field 001 at bits 4:2
    step("R9", 1'b1, 8'b1110_0111, 3'd1, 3'd4, 16'h1000);
    check("R9 plus two", pc_o, 16'h1002);
    step("R9 field 7", 1'b1, 8'b0001_1100, 3'd1, 3'd4, 16'h2000);
    // R2 wrap: bit 0 rotated by 7 reaches bit 1
    step("R2 wrap", 1'b1, 8'h01, 3'd7, 3'd0, 16'h0100);
    check("R2 wrap value", pc_o, 16'h0102);
    step("R2 no rotate", 1'b1, 8'h3C, 3'd0, 3'd0, 16'h0100);
    // R3 full clear and zero mask
    step("R3 mask 7", 1'b1, 8'hFF, 3'd0, 3'd7, 16'h4000);
    check("R3 mask 7 value", pc_o, 16'h4000);
    step("R3 mask 0", 1'b1, 8'hFE, 3'd0, 3'd0, 16'h4000);
    check("R3 mask 0 value", pc_o, 16'h3FFE);
    // R4 odd operand
    step("R4 lsb", 1'b1, 8'h01, 3'd0, 3'd0, 16'h0500);
    check("R4 lsb value", pc_o, 16'h0500);
    // R5 extremes and wrap
    step("R5 min", 1'b1, 8'h80, 3'd0, 3'd0, 16'h0000);
    check("R5 min value", pc_o, 16'hFF80);
    step("R5 wrap", 1'b1, 8'h7F, 3'd0, 3'd0, 16'hFFFF);
    check("R5 wrap value", pc_o, 16'h007D);
    // R7 hold, R6 done low
    for (int i = 0; i < 4; i++) step("R7 hold", 1'b0, 8'($urandom), 3'($urandom), 3'($urandom), 16'($urandom));
    // R8 back-to-back random, with occasional gaps
    for (int i = 0; i < 400; i++) begin
      logic st = ($urandom % 5) != 0;
      step(st ? "R8 random" : "R7 random gap", st, 8'($urandom), 3'($urandom), 3'($urandom), 16'($urandom));
    end
    step("R6 last", 1'b0, 8'h00, 3'd0, 3'd0, 16'h0000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule